// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. A one-cycle start pulse captures the column that came with the command together with a burst length code and an ordering bit taken from the programmed mode value. From the next cycle on, the block presents one column per beat. It moves to the following beat on each cycle in which the advance enable is high, and it marks the final beat with a last flag.

Fixed bursts of 1, 2, 4 and 8 beats stay inside the aligned block that holds the start column. The order within that block is either sequential (a wrapping count) or interleaved (the beat index XORed into the low bits). A full page burst walks all 512 columns of the page with wrap-around and continues until a stop arrives or a new burst starts. A stop input ends a burst of any length. A new start pulse is accepted on any clock and replaces the running burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: During and right after synchronous reset, `beat_valid_o` and `beat_last_o` are 0.
- R2: One cycle after `start_i` is high, `beat_valid_o` is 1 and `col_o` equals the `start_col_i` value sampled with it. This holds whatever `adv_i` and `stop_i` do in that cycle and whether or not a burst was running. A start in the same cycle as a stop wins.
- R3: The length code sampled with the start selects the burst: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The unused codes 4, 5 and 6 give a single beat. Changing the code or the order bit during a burst has no effect.
- R4: While a burst is valid, a high `adv_i` moves to the next beat in the following cycle. A low `adv_i` holds `col_o`, `beat_valid_o` and `beat_last_o` unchanged.
- R5: With order bit 0 and a fixed length BL = 2^k, beat n has the upper 9-k bits of the start column and the low k bits equal to (start low bits + n) mod BL.
- R6: With order bit 1 and a fixed length BL = 2^k, beat n has the upper bits of the start column and the low k bits equal to start low bits XOR n.
- R7: In a full page burst, beat n is (start column + n) mod 512 regardless of the order bit, `beat_last_o` stays 0, and the burst runs until a stop or a new start.
- R8: For fixed lengths, `beat_last_o` is 1 exactly on beat BL-1. An advance on that beat makes `beat_valid_o` 0 in the next cycle.
- R9: A `stop_i` without `start_i` makes `beat_valid_o` 0 in the next cycle, at every burst length including full page.
- R10: While no burst is valid, `adv_i` and `stop_i` have no effect: `beat_valid_o` stays 0 until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst (read or write command accepted) |
| start_col_i | input | 9 | Column captured with the command |
| len_code_i | input | 3 | Burst length code from the mode value |
| order_ilv_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| stop_i | input | 1 | Terminate the running burst |
| adv_i | input | 1 | Advance to the next beat |
| col_o | output | 9 | Column of the current beat |
| beat_valid_o | output | 1 | A burst beat is being presented |
| beat_last_o | output | 1 | The current beat is the final beat of a fixed burst |

## Verification
Each result is due exactly one clock after the inputs that cause it. A start shows its column, a stop or a final advance clears the valid flag, and a plain advance shows the next column, all on the next rising edge. There is no further pipeline stage. The bench drives inputs on the falling edge and updates its own expected state at that moment. On the next falling edge, after the one rising edge has taken effect, it compares the valid flag, the column and the last flag. This way every comparison falls in the single cycle where the result is due.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Width of the length code field in the mode value
    localparam int LEN_CODE_W = 3;
    // Largest fixed burst is 2**MAX_LOG beats
    localparam int MAX_LOG    = 3;
    localparam int LOG_W      = $clog2(MAX_LOG + 1);
    // Code that selects a full page burst
    localparam logic [LEN_CODE_W-1:0] PAGE_CODE = 3'd7;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        logic              full_page;
        order_e            order;
        logic [LOG_W-1:0]  log_len;
    } burst_cfg_t;

    // Translate the mode fields into a burst configuration.
    // Unused codes fall back to a single beat.
    function automatic burst_cfg_t decode_cfg(
        input logic [LEN_CODE_W-1:0] code,
        input logic                  ilv
    );
        burst_cfg_t c;
        c.full_page = 1'b0;
        c.order     = ilv ? ORD_ILV : ORD_SEQ;
        c.log_len   = '0;
        if (code == PAGE_CODE) begin
            c.full_page = 1'b1;
        end else if (int'(code) <= MAX_LOG) begin
            c.log_len = code[LOG_W-1:0];
        end
        return c;
    endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  burst_cfg_t       cfg_i,
    input  logic             stop_i,
    input  logic             adv_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output burst_cfg_t       cfg_o,
    output logic             last_o
);

    logic             active_q;
    logic [COL_W-1:0] beat_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] final_beat;

    // Index of the closing beat of a fixed burst
    assign final_beat = COL_W'((1 << cfg_q.log_len) - 1);
    assign last_o     = active_q && !cfg_q.full_page && (beat_q == final_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            cfg_q    <= cfg_i;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q && adv_i) begin
            if (last_o) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign cfg_o    = cfg_q;

    AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (rst)
        active_q && adv_i && !start_i && !stop_i && !last_o
        |=> active_q && beat_q == $past(beat_q) + 1'b1);  // R4

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(cfg_q));  // R3

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    localparam int NCAND = MAX_LOG + 1;

    logic [COL_W-1:0] seq_cand [NCAND];
    logic [COL_W-1:0] ilv_cand [NCAND];
    logic [COL_W-1:0] page_col;

    // One candidate pair per fixed length: the low L bits move, the rest stay
    for (genvar L = 0; L < NCAND; L++) begin : g_len
        if (L == 0) begin : g_single
            assign seq_cand[L] = base_i;
            assign ilv_cand[L] = base_i;
        end else begin : g_multi
            logic [L-1:0] low_sum;
            assign low_sum     = base_i[L-1:0] + beat_i[L-1:0];
            assign seq_cand[L] = {base_i[COL_W-1:L], low_sum};
            assign ilv_cand[L] = {base_i[COL_W-1:L], base_i[L-1:0] ^ beat_i[L-1:0]};
        end
    end

    assign page_col = base_i + beat_i;

    always_comb begin
        if (cfg_i.full_page) begin
            col_o = page_col;
        end else if (cfg_i.order == ORD_ILV) begin
            col_o = ilv_cand[cfg_i.log_len];
        end else begin
            col_o = seq_cand[cfg_i.log_len];
        end
    end

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        active_i && !cfg_i.full_page
        |-> col_o[COL_W-1:MAX_LOG] == base_i[COL_W-1:MAX_LOG]);  // R5

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  order_ilv_i,
    input  logic                  stop_i,
    input  logic                  adv_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  beat_valid_o,
    output logic                  beat_last_o
);

    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_run;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat;
    logic             active;

    assign cfg_in = decode_cfg(len_code_i, order_ilv_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (start_i) begin
            base_q <= start_col_i;
        end
    end

    burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cfg_i    (cfg_in),
        .stop_i   (stop_i),
        .adv_i    (adv_i),
        .active_o (active),
        .beat_o   (beat),
        .cfg_o    (cfg_run),
        .last_o   (beat_last_o)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .base_i   (base_q),
        .beat_i   (beat),
        .cfg_i    (cfg_run),
        .col_o    (col_o)
    );

    assign beat_valid_o = active;

    AST_START_LOADS_COL: assert property (@(posedge clk) disable iff (rst)
        start_i |=> beat_valid_o && col_o == $past(start_col_i));  // R2

    AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && !start_i && !stop_i && !adv_i
        |=> beat_valid_o && $stable(col_o) && $stable(beat_last_o));  // R4

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stop_i && !start_i |=> !beat_valid_o);  // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        !beat_valid_o && !start_i |=> !beat_valid_o);  // R10

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        beat_last_o && adv_i && !start_i && !stop_i |=> !beat_valid_o);  // R8

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_last_o |-> beat_valid_o);  // R8

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && cfg_run.full_page && adv_i && !start_i && !stop_i
        |=> beat_valid_o && col_o == $past(col_o) + 1'b1);  // R7

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       adv_i = 1'b0;
    logic [8:0] col_o;
    logic       beat_valid_o;
    logic       beat_last_o;

    int tests = 0;
    int fails = 0;

    // Bench reference state
    bit         m_act = 0;
    int         m_base = 0;
    int         m_beat = 0;
    int         m_code = 0;
    bit         m_ilv = 0;
    string      m_why = "R1";

    always #5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .order_ilv_i  (order_ilv_i),
        .stop_i       (stop_i),
        .adv_i        (adv_i),
        .col_o        (col_o),
        .beat_valid_o (beat_valid_o),
        .beat_last_o  (beat_last_o)
    );

    // Burst length from the code; 0 means full page
    function automatic int blen(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int n, input int code, input bit ilv);
        int bl = blen(code);
        int lo;
        int blk;
        if (bl == 0) return (base + n) % 512;
        lo  = base % bl;
        blk = base - lo;
        if (ilv) return blk + (lo ^ n);
        return blk + ((lo + n) % bl);
    endfunction

    function automatic bit exp_last();
        int bl = blen(m_code);
        return m_act && bl != 0 && m_beat == bl - 1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, advance the model,
    // then compare outputs at the next falling edge.
    task automatic step(input bit st, input int c, input int lc, input bit md,
                        input bit sp, input bit ad);
        start_i     = st;
        start_col_i = 9'(c);
        len_code_i  = 3'(lc);
        order_ilv_i = md;
        stop_i      = sp;
        adv_i       = ad;
        if (st) begin
            m_act = 1; m_base = c; m_beat = 0; m_code = lc; m_ilv = md; m_why = "R2";
        end else if (sp) begin
            m_why = m_act ? "R9" : "R10";
            m_act = 0;
        end else if (m_act && ad) begin
            if (exp_last()) begin
                m_act = 0; m_why = "R8";
            end else begin
                m_beat++; m_why = "R4";
            end
        end else begin
            m_why = m_act ? "R4" : "R10";
        end
        @(negedge clk);
        check(m_why, "valid", int'(beat_valid_o), int'(m_act));
        if (m_act) begin
            string ctag;
            if (blen(m_code) == 0) ctag = "R7";
            else if (m_ilv)        ctag = "R6";
            else                   ctag = "R5";
            check(ctag, "col", int'(col_o), exp_col(m_base, m_beat, m_code, m_ilv));
            check(blen(m_code) == 0 ? "R7" : "R3,R8", "last",
                  int'(beat_last_o), int'(exp_last()));
        end else begin
            check("R8", "last while idle", int'(beat_last_o), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(beat_valid_o), 0);
        check("R1", "last in reset", int'(beat_last_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", int'(beat_valid_o), 0);
        check("R1", "last after reset", int'(beat_last_o), 0);

        // R10: idle ignores advance and stop
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 1);

        // R5: 4-beat sequential from 0x0E -> 0E 0F 0C 0D
        step(1, 9'h00E, 2, 0, 0, 0);
        check("R5", "literal beat0", int'(col_o), 9'h00E);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        check("R5", "literal wrap", int'(col_o), 9'h00C);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);

        // R6: 8-beat interleaved from 0x15, with hold cycles (R4)
        step(1, 9'h015, 3, 1, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
        check("R6", "literal beat3", int'(col_o), 9'h016);
        step(0, 0, 5, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1);

        // R7: full page wraps past 511, then a stop ends it (R9)
        step(1, 9'h1FE, 7, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1);
        check("R7", "literal wrap", int'(col_o), 9'h002);
        step(0, 0, 0, 0, 1, 1);

        // R2: start interrupts a burst; start beats a same-cycle stop
        step(1, 9'h100, 3, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(1, 9'h0A3, 1, 0, 1, 1);
        step(0, 0, 0, 0, 0, 1);

        // R3: reserved code gives one beat; R9 stop on a 1-beat burst
        step(1, 9'h0C7, 5, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(1, 9'h033, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int  r  = int'($urandom_range(0, 99));
            bit  st = (r < 8);
            bit  sp = ($urandom_range(0, 39) == 0);
            bit  ad = ($urandom_range(0, 3) != 0);
            int  cl = int'($urandom_range(0, 7));
            step(st, int'($urandom_range(0, 511)), cl, 1'($urandom_range(0, 1)), sp, ad);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule